// File: doc/BRIEF.md
# Self-Correcting Six-State Counter

A three-bit synchronous counter whose bits are named A (most significant), B and C. While counting is enabled it steps through six codes and skips the two codes 011 and 111. The six states are ST_ZERO (000), ST_ONE (001), ST_TWO (010), ST_FOUR (100), ST_FIVE (101) and ST_SIX (110). The two unused codes are ST_GAP3 (011) and ST_GAP7 (111).

Each bit's next value comes from JK flip-flop equations. These are J=K=B for bit A, J=C with K=1 for bit B, and J=not B with K=1 for bit C. All three bits update on the same clock edge. The equations also give each unused code a defined successor. If a disturbance leaves the counter in an unused code, one enabled clock returns it to the cycle, and no reset is needed. A flag output reports when the present code lies outside the cycle.

The named transitions are:
- step_0 ST_ZERO→ST_ONE
- step_1 ST_ONE→ST_TWO
- step_2 ST_TWO→ST_FOUR
- step_4 ST_FOUR→ST_FIVE
- step_5 ST_FIVE→ST_SIX
- wrap ST_SIX→ST_ZERO
- heal3 ST_GAP3→ST_FOUR
- heal7 ST_GAP7→ST_ZERO
- hold (any state to itself while enable is low)
- clear (any state to ST_ZERO on reset)

Top module: `sixcyc_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, the state becomes 000 at that edge, whatever the value of `cnt_en`.
- R2: With `cnt_en` high and `rst` low, each rising edge advances the state in the order 000→001→010→100→101→110→000. The codes on `state_q` use bit 2 = A, bit 1 = B and bit 0 = C.
- R3: From code 011, one enabled edge gives 100.
- R4: From code 111, one enabled edge gives 000.
- R5: With `cnt_en` low and `rst` low, the state holds its value across clock edges. This includes an unused code.
- R6: `off_cycle` is 1 exactly when `state_q` is 011 or 111, and it follows the state with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all three state bits |
| rst | input | 1 | Synchronous reset, active high, forces 000 |
| cnt_en | input | 1 | Count enable, active high |
| state_q | output | 3 | Present code, bit 2 = A, bit 1 = B, bit 0 = C |
| off_cycle | output | 1 | High while the present code is 011 or 111 |

## Verification
The six-state cycle is run for two full laps from reset. This shows the skip from 010 to 100 and the wrap from 110 back to 000.

An enable pattern that alternates and pauses shows that holding and stepping are told apart on every edge. Asserting reset together with enable, partway through the cycle, separates the reset priority from normal counting.

Each unused code is placed in the state register as an injected upset, since no port can load it. The bench then checks the flag, one step of recovery, and holding in the unused code while enable is low. This separates the 011 and 111 recovery paths from each other and from the legal transitions.

// File: rtl/sixcyc_pkg.sv
package sixcyc_pkg;

    localparam int CNT_W = 3;
    localparam int IDX_A = 2;
    localparam int IDX_B = 1;
    localparam int IDX_C = 0;

    typedef enum logic [CNT_W-1:0] {
        ST_ZERO = 3'b000,
        ST_ONE  = 3'b001,
        ST_TWO  = 3'b010,
        ST_GAP3 = 3'b011,
        ST_FOUR = 3'b100,
        ST_FIVE = 3'b101,
        ST_SIX  = 3'b110,
        ST_GAP7 = 3'b111
    } cnt_state_e;

endpackage

// File: rtl/sixcyc_jk_cell.sv
// One JK flip-flop's next-value function: set, reset, toggle or keep.
module sixcyc_jk_cell (
    input  logic j,
    input  logic k,
    input  logic q,
    output logic q_next
);
    always_comb begin
        unique case ({j, k})
            2'b00: q_next = q;
            2'b01: q_next = 1'b0;
            2'b10: q_next = 1'b1;
            2'b11: q_next = ~q;
        endcase
    end
endmodule

// File: rtl/sixcyc_next.sv
// Next-state logic: the J and K inputs of every bit, then one JK cell per bit.
module sixcyc_next
    import sixcyc_pkg::*;
(
    input  cnt_state_e cur,
    output cnt_state_e nxt
);
    logic [CNT_W-1:0] cur_v;
    logic [CNT_W-1:0] j_v;
    logic [CNT_W-1:0] k_v;
    logic [CNT_W-1:0] q_n;

    assign cur_v = cur;

    always_comb begin
        j_v[IDX_A] = cur_v[IDX_B];
        k_v[IDX_A] = cur_v[IDX_B];
        j_v[IDX_B] = cur_v[IDX_C];
        k_v[IDX_B] = 1'b1;
        j_v[IDX_C] = ~cur_v[IDX_B];
        k_v[IDX_C] = 1'b1;
    end

    for (genvar g = 0; g < CNT_W; g++) begin : g_bit
        sixcyc_jk_cell u_cell (
            .j      (j_v[g]),
            .k      (k_v[g]),
            .q      (cur_v[g]),
            .q_next (q_n[g])
        );
    end

    assign nxt = cnt_state_e'(q_n);
endmodule

// File: rtl/sixcyc_state_reg.sv
// State register: reset has priority over enable.
module sixcyc_state_reg
    import sixcyc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  cnt_state_e d,
    output cnt_state_e q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= ST_ZERO;
        end else if (en) begin
            q <= d;
        end
    end
endmodule

// File: rtl/sixcyc_outputs.sv
// Output decode: the state code and the flag for codes outside the cycle.
module sixcyc_outputs
    import sixcyc_pkg::*;
(
    input  cnt_state_e       cur,
    output logic [CNT_W-1:0] code,
    output logic             off_cycle
);
    assign code = cur;

    always_comb begin
        unique case (cur)
            ST_ZERO, ST_ONE, ST_TWO,
            ST_FOUR, ST_FIVE, ST_SIX: off_cycle = 1'b0;
            ST_GAP3, ST_GAP7:         off_cycle = 1'b1;
        endcase
    end
endmodule

// File: rtl/sixcyc_counter.sv
module sixcyc_counter
    import sixcyc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] state_q,
    output logic             off_cycle
);
    cnt_state_e cur_state;
    cnt_state_e nxt_state;

    sixcyc_next u_next (
        .cur (cur_state),
        .nxt (nxt_state)
    );

    sixcyc_state_reg u_reg (
        .clk (clk),
        .rst (rst),
        .en  (cnt_en),
        .d   (nxt_state),
        .q   (cur_state)
    );

    sixcyc_outputs u_out (
        .cur       (cur_state),
        .code      (state_q),
        .off_cycle (off_cycle)
    );
endmodule

// File: rtl/sixcyc_counter_chk.sv
module sixcyc_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       cnt_en,
    input logic [2:0] state_q,
    input logic [2:0] nxt_code,
    input logic       off_cycle
);
    a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> state_q == 3'b000);

    a_r2_step0: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b000 |-> nxt_code == 3'b001);
    a_r2_step1: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b001 |-> nxt_code == 3'b010);
    a_r2_step2: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b010 |-> nxt_code == 3'b100);
    a_r2_step4: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b100 |-> nxt_code == 3'b101);
    a_r2_step5: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b101 |-> nxt_code == 3'b110);
    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b110 |-> nxt_code == 3'b000);

    a_r3_heal3: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b011 |-> nxt_code == 3'b100);

    a_r4_heal7: assert property (@(posedge clk) disable iff (rst)
        state_q == 3'b111 |-> nxt_code == 3'b000);

    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(state_q));

    a_r6_flag: assert property (@(posedge clk) disable iff (rst)
        off_cycle == (state_q[1] && state_q[0]));
endmodule

bind sixcyc_counter sixcyc_counter_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .state_q   (state_q),
    .nxt_code  (nxt_state),
    .off_cycle (off_cycle)
);

// File: tb/sixcyc_counter_tb.sv
`timescale 1ns/1ps
module sixcyc_counter_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic [2:0] state_q;
    logic       off_cycle;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sixcyc_counter u_dut (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .state_q   (state_q),
        .off_cycle (off_cycle)
    );

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    function automatic logic [2:0] succ(input logic [2:0] s);
        case (s)
            3'b000: return 3'b001;
            3'b001: return 3'b010;
            3'b010: return 3'b100;
            3'b100: return 3'b101;
            3'b101: return 3'b110;
            3'b110: return 3'b000;
            3'b011: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1; cnt_en = 1'b1;
        tick(); tick();
        chk("R1 reset state", state_q, 0);
        chk("R6 flag after reset", off_cycle, 0);
        rst = 1'b0;
    endtask

    task automatic t_cycle();
        logic [2:0] exp = 3'b000;
        cnt_en = 1'b1;
        for (int i = 0; i < 12; i++) begin
            exp = succ(exp);
            tick();
            chk("R2 cycle step", state_q, exp);
            chk("R6 flag legal", off_cycle, 0);
        end
    endtask

    task automatic t_hold();
        logic [2:0] exp = state_q;
        for (int i = 0; i < 10; i++) begin
            cnt_en = (i % 3) != 2;
            tick();
            if (cnt_en) exp = succ(exp);
            chk(cnt_en ? "R2 enabled step" : "R5 hold", state_q, exp);
        end
        cnt_en = 1'b1;
    endtask

    task automatic t_reset_priority();
        cnt_en = 1'b1;
        tick(); tick();
        rst = 1'b1;
        tick();
        chk("R1 reset over enable", state_q, 0);
        rst = 1'b0;
        tick();
        chk("R2 first step after reset", state_q, 1);
    endtask

    task automatic t_heal3();
        cnt_en = 1'b1;
        tick();
        force u_dut.u_reg.q = sixcyc_pkg::ST_GAP3;
        #1;
        chk("R6 flag on 011", off_cycle, 1);
        release u_dut.u_reg.q;
        tick();
        chk("R3 011 recovers", state_q, 3'b100);
        chk("R6 flag clear after 011", off_cycle, 0);
    endtask

    task automatic t_heal7();
        cnt_en = 1'b1;
        tick();
        force u_dut.u_reg.q = sixcyc_pkg::ST_GAP7;
        cnt_en = 1'b0;
        #1;
        chk("R6 flag on 111", off_cycle, 1);
        release u_dut.u_reg.q;
        tick();
        chk("R5 hold in 111", state_q, 3'b111);
        chk("R6 flag held 111", off_cycle, 1);
        cnt_en = 1'b1;
        tick();
        chk("R4 111 recovers", state_q, 3'b000);
        chk("R6 flag clear after 111", off_cycle, 0);
        tick();
        chk("R2 step after recovery", state_q, 3'b001);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_cycle();
        t_hold();
        t_reset_priority();
        t_heal3();
        t_heal7();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule